// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control flow for one warp of 32 threads that share a single program counter. It holds a small stack of entries. Each entry has a reconvergence PC, a next PC and an active thread mask. The top entry drives the fetch PC and the execution mask of the warp. After each instruction the front end reports either a plain PC advance or a resolved branch. A resolved branch carries a per-thread taken mask, a target, a fall-through PC and the reconvergence PC that the compiler computed.

When a branch splits the active threads, the top entry's next PC becomes the reconvergence PC. Two entries are then pushed, one for each thread group. The group with fewer threads is pushed last, so it runs first; on a tie the not-taken group runs first. When the running path's next PC reaches the reconvergence PC of its entry, that entry is popped. Pops repeat while the new top entry is also at its own reconvergence point, so nested paths that join at the same PC unwind in one sequence.

The stack has 6 entries and a 3-bit pointer. A split that does not fit raises a sticky error flag and leaves the stack unchanged. The block is controlled by a two-state machine:
- `ST_RUN` accepts one event per cycle, and `ready` is high.
- `ST_CHECK` follows every accepted event and pops while the top entry's next PC equals its reconvergence PC. It stays in `ST_CHECK` on a pop, and returns to `ST_RUN` when no pop is due.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the pointer is 0, `fetch_pc` equals `start_pc` (sampled while reset is held), `exec_mask` is all ones, `ovf_err` is 0 and `ready` is 1.
- R2: An accepted PC advance sets `fetch_pc` to `adv_pc` and leaves `exec_mask` and the pointer unchanged, unless a pop is due.
- R3: For a branch, only taken bits inside the current mask count. If none count, `fetch_pc` becomes the fall-through PC. If all active threads are taken, `fetch_pc` becomes the target. In both cases nothing is pushed.
- R4: A split branch raises the pointer by 2. If fewer threads are taken than not taken, the taken group runs first: `fetch_pc` is the target and `exec_mask` is the taken subset.
- R5: On a split with equal thread counts, or with more threads taken, the not-taken group runs first: `fetch_pc` is the fall-through PC and `exec_mask` is the not-taken subset.
- R6: When the running path's PC reaches its reconvergence PC, the entry is popped. The sibling group then runs with its own mask from its own start PC.
- R7: When both groups have reached the reconvergence PC, the warp runs there with the mask it had before the split, and the pointer is back at its old value.
- R8: Pops cascade. While the new top entry's next PC equals its reconvergence PC it is also popped, and the pointer falls by exactly one per cycle.
- R9: A split that would need an entry beyond index 5 sets `ovf_err`, which stays set until reset, and leaves the pointer, `fetch_pc` and `exec_mask` unchanged. The pointer never exceeds 5.
- R10: `ready` is low in the cycle after each accepted event. Events presented while `ready` is low are ignored. During that cycle the pointer never rises.
- R11: `exec_mask` is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pc | input | 32 | PC loaded into the bottom entry during reset |
| br_valid | input | 1 | Resolved branch event; has priority over `adv_valid` |
| br_taken | input | 32 | Per-thread taken bits (bit i is thread i) |
| br_target | input | 32 | Branch target PC |
| br_fallthru | input | 32 | Fall-through PC |
| br_reconv | input | 32 | Reconvergence PC of this branch |
| adv_valid | input | 1 | Non-branch PC advance event |
| adv_pc | input | 32 | Next PC for the advance |
| fetch_pc | output | 32 | Next PC of the top entry |
| exec_mask | output | 32 | Active mask of the top entry |
| stk_ptr | output | 3 | Index of the top entry |
| ready | output | 1 | High when an event is accepted this cycle |
| ovf_err | output | 1 | Sticky split-overflow flag |

## Verification
The bench uses the following branch patterns, each chosen to distinguish one behaviour:
- An all-taken branch and a none-taken branch show that a uniform branch only redirects the PC.
- A branch whose taken bits all lie outside the active mask proves that inactive threads are ignored.
- A minority-taken split separates "fewer threads first" from "taken first".
- A 16/16 tie separates the not-taken preference from the count rule.
- A nested split that shares its reconvergence PC with the outer split shows that pops cascade to the correct group.
- A third split at pointer 4 shows that overflow is rejected without corrupting the stack.

An event held high across the busy cycle shows that such events are dropped.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_CHECK = 1'b1
    } stk_state_e;

    typedef enum logic [1:0] {
        BR_FALL  = 2'd0,
        BR_TAKEN = 2'd1,
        BR_SPLIT = 2'd2
    } br_kind_e;
endpackage

// File: rtl/simt_path_split.sv
module simt_path_split
    import simt_stack_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] taken,
    output logic [LANES-1:0] tk_mask,
    output logic [LANES-1:0] nt_mask,
    output br_kind_e         kind,
    output logic             taken_first
);
    localparam int CW = $clog2(LANES + 1);

    function automatic logic [CW-1:0] ones(input logic [LANES-1:0] v);
        logic [CW-1:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) n = n + CW'(v[i]);
        return n;
    endfunction

    logic [CW-1:0] cnt_tk, cnt_nt;

    always_comb begin
        tk_mask = taken & cur_mask;
        nt_mask = cur_mask & ~taken;
        cnt_tk  = ones(tk_mask);
        cnt_nt  = ones(nt_mask);
        if (tk_mask == '0)      kind = BR_FALL;
        else if (nt_mask == '0) kind = BR_TAKEN;
        else                    kind = BR_SPLIT;
        // strict compare: a tie sends the not-taken group first
        taken_first = (cnt_tk < cnt_nt);
    end
endmodule

// File: rtl/simt_stack_regs.sv
module simt_stack_regs #(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  start_pc,
    input  logic [PTR_W-1:0] top_idx,
    input  logic             npc_we,
    input  logic [PC_W-1:0]  npc_wval,
    input  logic             push_we,
    input  logic [PC_W-1:0]  push_rpc,
    input  logic [PC_W-1:0]  later_npc,
    input  logic [LANES-1:0] later_mask,
    input  logic [PC_W-1:0]  early_npc,
    input  logic [LANES-1:0] early_mask,
    output logic [PC_W-1:0]  top_rpc,
    output logic [PC_W-1:0]  top_npc,
    output logic [LANES-1:0] top_mask
);
    logic [PC_W-1:0]  rpc_q  [DEPTH];
    logic [PC_W-1:0]  npc_q  [DEPTH];
    logic [LANES-1:0] mask_q [DEPTH];

    logic [PTR_W:0] idx_p1, idx_p2;
    assign idx_p1 = {1'b0, top_idx} + (PTR_W+1)'(1);
    assign idx_p2 = {1'b0, top_idx} + (PTR_W+1)'(2);

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [PTR_W:0] SLOT = (PTR_W+1)'(i);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rpc_q[i]  <= '1;
                npc_q[i]  <= (i == 0) ? start_pc : '0;
                mask_q[i] <= (i == 0) ? '1 : '0;
            end else if (push_we && idx_p1 == SLOT) begin
                rpc_q[i]  <= push_rpc;
                npc_q[i]  <= later_npc;
                mask_q[i] <= later_mask;
            end else if (push_we && idx_p2 == SLOT) begin
                rpc_q[i]  <= push_rpc;
                npc_q[i]  <= early_npc;
                mask_q[i] <= early_mask;
            end else if (npc_we && {1'b0, top_idx} == SLOT) begin
                npc_q[i]  <= npc_wval;
            end
        end
    end

    always_comb begin
        top_rpc  = rpc_q[0];
        top_npc  = npc_q[0];
        top_mask = mask_q[0];
        for (int i = 1; i < DEPTH; i++) begin
            if (top_idx == PTR_W'(i)) begin
                top_rpc  = rpc_q[i];
                top_npc  = npc_q[i];
                top_mask = mask_q[i];
            end
        end
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stack_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PC_W  = 32,
    parameter int DEPTH = 6,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  start_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken,
    input  logic [PC_W-1:0]  br_target,
    input  logic [PC_W-1:0]  br_fallthru,
    input  logic [PC_W-1:0]  br_reconv,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic [LANES-1:0] exec_mask,
    output logic [PTR_W-1:0] stk_ptr,
    output logic             ready,
    output logic             ovf_err
);
    localparam logic [PTR_W:0] TOP_MAX = (PTR_W+1)'(DEPTH - 1);

    stk_state_e       state_q, state_d;
    logic [PTR_W-1:0] sp_q, sp_d;
    logic             ovf_q, ovf_set;

    logic [PC_W-1:0]  top_rpc, top_npc, npc_wval;
    logic [LANES-1:0] top_mask, tk_mask, nt_mask;
    logic             npc_we, push_we, taken_first, need_pop, room;
    br_kind_e         kind;

    simt_path_split #(.LANES(LANES)) u_split (
        .cur_mask    (top_mask),
        .taken       (br_taken),
        .tk_mask     (tk_mask),
        .nt_mask     (nt_mask),
        .kind        (kind),
        .taken_first (taken_first)
    );

    simt_stack_regs #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pc   (start_pc),
        .top_idx    (sp_q),
        .npc_we     (npc_we),
        .npc_wval   (npc_wval),
        .push_we    (push_we),
        .push_rpc   (br_reconv),
        .later_npc  (taken_first ? br_fallthru : br_target),
        .later_mask (taken_first ? nt_mask : tk_mask),
        .early_npc  (taken_first ? br_target : br_fallthru),
        .early_mask (taken_first ? tk_mask : nt_mask),
        .top_rpc    (top_rpc),
        .top_npc    (top_npc),
        .top_mask   (top_mask)
    );

    assign need_pop = (sp_q != '0) && (top_npc == top_rpc);
    assign room     = ({1'b0, sp_q} + (PTR_W+1)'(2)) <= TOP_MAX;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            sp_q    <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            if (ovf_set) ovf_q <= 1'b1;
        end
    end

    // next state and stack controls
    always_comb begin
        state_d  = state_q;
        sp_d     = sp_q;
        npc_we   = 1'b0;
        npc_wval = top_npc;
        push_we  = 1'b0;
        ovf_set  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (br_valid) begin
                    state_d = ST_CHECK;
                    unique case (kind)
                        BR_FALL: begin
                            npc_we   = 1'b1;
                            npc_wval = br_fallthru;
                        end
                        BR_TAKEN: begin
                            npc_we   = 1'b1;
                            npc_wval = br_target;
                        end
                        default: begin
                            if (room) begin
                                npc_we   = 1'b1;
                                npc_wval = br_reconv;
                                push_we  = 1'b1;
                                sp_d     = sp_q + PTR_W'(2);
                            end else begin
                                ovf_set  = 1'b1;
                            end
                        end
                    endcase
                end else if (adv_valid) begin
                    state_d  = ST_CHECK;
                    npc_we   = 1'b1;
                    npc_wval = adv_pc;
                end
            end
            ST_CHECK: begin
                if (need_pop) sp_d = sp_q - PTR_W'(1);
                else          state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        fetch_pc  = top_npc;
        exec_mask = top_mask;
        stk_ptr   = sp_q;
        ready     = (state_q == ST_RUN);
        ovf_err   = ovf_q;
    end
endmodule

// File: rtl/simt_stack_checker.sv
module simt_stack_checker #(
    parameter int LANES = 32,
    parameter int DEPTH = 6,
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             br_valid,
    input logic [PTR_W-1:0] stk_ptr,
    input logic [LANES-1:0] exec_mask,
    input logic             ovf_err
);
    assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ptr <= PTR_W'(DEPTH - 1));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    assert_ovf_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_err) |-> (stk_ptr == $past(stk_ptr)));

    assert_mask_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_mask != '0);

    assert_busy_no_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (stk_ptr <= $past(stk_ptr)));

    assert_split_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && br_valid) |=> ((stk_ptr == $past(stk_ptr)) ||
                                 (stk_ptr == $past(stk_ptr) + PTR_W'(2))));

    assert_pop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_ptr < $past(stk_ptr)) |-> (stk_ptr == $past(stk_ptr) - PTR_W'(1)));
endmodule

bind simt_reconv_stack simt_stack_checker #(.LANES(LANES), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .br_valid  (br_valid),
    .stk_ptr   (stk_ptr),
    .exec_mask (exec_mask),
    .ovf_err   (ovf_err)
);

// File: tb/tb_simt_reconv_stack.sv
`timescale 1ns/1ps
module tb_simt_reconv_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] start_pc = 32'h100;
    logic        br_valid = 1'b0;
    logic [31:0] br_taken = '0, br_target = '0, br_fallthru = '0, br_reconv = '0;
    logic        adv_valid = 1'b0;
    logic [31:0] adv_pc = '0;
    logic [31:0] fetch_pc, exec_mask;
    logic [2:0]  stk_ptr;
    logic        ready, ovf_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    simt_reconv_stack dut (
        .clk(clk), .rst_n(rst_n), .start_pc(start_pc),
        .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
        .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .fetch_pc(fetch_pc), .exec_mask(exec_mask), .stk_ptr(stk_ptr),
        .ready(ready), .ovf_err(ovf_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic do_adv(input logic [31:0] pc);
        @(negedge clk);
        adv_valid = 1'b1;
        adv_pc    = pc;
        @(negedge clk);
        adv_valid = 1'b0;
        wait_ready();
    endtask

    task automatic do_branch(input logic [31:0] tk, tgt, ft, rc);
        @(negedge clk);
        br_valid = 1'b1; br_taken = tk; br_target = tgt; br_fallthru = ft; br_reconv = rc;
        @(negedge clk);
        br_valid = 1'b0;
        wait_ready();
    endtask

    task automatic expect_top(input string tag, input logic [31:0] pc, mask, input int ptr);
        chk({tag, " fetch_pc"}, fetch_pc, pc);
        chk({tag, " exec_mask"}, exec_mask, mask);
        chk({tag, " stk_ptr"}, {29'd0, stk_ptr}, 32'(ptr));
    endtask

    task automatic t_reset();
        expect_top("R1 reset", 32'h100, 32'hFFFF_FFFF, 0);
        chk("R1 ovf_err", {31'd0, ovf_err}, 32'd0);
        chk("R1 ready", {31'd0, ready}, 32'd1);
    endtask

    task automatic t_uniform();
        do_adv(32'h104);
        expect_top("R2 advance", 32'h104, 32'hFFFF_FFFF, 0);
        do_branch(32'hFFFF_FFFF, 32'h200, 32'h108, 32'h300);
        expect_top("R3 all taken", 32'h200, 32'hFFFF_FFFF, 0);
        do_branch(32'h0, 32'h280, 32'h204, 32'h300);
        expect_top("R3 none taken", 32'h204, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_minority();
        do_branch(32'h0000_000F, 32'h300, 32'h210, 32'h400);
        expect_top("R4 taken minority first", 32'h300, 32'h0000_000F, 2);
        do_adv(32'h304);
        expect_top("R2 advance in path", 32'h304, 32'h0000_000F, 2);
        do_adv(32'h400);
        expect_top("R6 sibling after pop", 32'h210, 32'hFFFF_FFF0, 1);
        do_adv(32'h400);
        expect_top("R7 rejoin", 32'h400, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_tie();
        do_branch(32'h0000_FFFF, 32'hA00, 32'hB00, 32'hC00);
        expect_top("R5 tie not-taken first", 32'hB00, 32'hFFFF_0000, 2);
        do_branch(32'h0000_FFFF, 32'hD00, 32'hB40, 32'hE00);
        expect_top("R3 inactive taken bits ignored", 32'hB40, 32'hFFFF_0000, 2);
        do_branch(32'hFFFF_FFFF, 32'hB80, 32'hB44, 32'hE00);
        expect_top("R3 all active taken", 32'hB80, 32'hFFFF_0000, 2);
        do_adv(32'hC00);
        expect_top("R6 taken half after pop", 32'hA00, 32'h0000_FFFF, 1);
        do_adv(32'hC00);
        expect_top("R7 rejoin after tie", 32'hC00, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        adv_valid = 1'b1;
        adv_pc    = 32'h150;
        @(negedge clk);
        chk("R10 ready low after event", {31'd0, ready}, 32'd0);
        adv_pc = 32'h160;
        @(negedge clk);
        adv_valid = 1'b0;
        wait_ready();
        expect_top("R10 busy event ignored", 32'h150, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_nested_ovf();
        do_branch(32'h0000_00FF, 32'h500, 32'h600, 32'h900);
        expect_top("R4 outer split", 32'h500, 32'h0000_00FF, 2);
        do_branch(32'h0000_000F, 32'h700, 32'h800, 32'h900);
        expect_top("R5 inner tie", 32'h800, 32'h0000_00F0, 4);
        do_branch(32'h0000_0030, 32'hF00, 32'hF10, 32'hF20);
        chk("R9 ovf_err set", {31'd0, ovf_err}, 32'd1);
        expect_top("R9 stack unchanged", 32'h800, 32'h0000_00F0, 4);
        do_adv(32'h900);
        expect_top("R6 inner sibling", 32'h700, 32'h0000_000F, 3);
        do_adv(32'h900);
        expect_top("R8 cascade pop", 32'h600, 32'hFFFF_FF00, 1);
        do_adv(32'h900);
        expect_top("R7 nested rejoin", 32'h900, 32'hFFFF_FFFF, 0);
        chk("R9 ovf_err sticky", {31'd0, ovf_err}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_minority();
        t_tie();
        t_busy_ignore();
        t_nested_ovf();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule